// File: doc/BRIEF.md
# Tagged Branch Target Buffer

This block sits beside the instruction fetch stage and supplies the next fetch address in the same cycle as the fetch PC, before the instruction has been decoded. It is a direct-mapped table. Each slot keeps the complete address of a control instruction as its tag, along with a valid flag, the last seen destination and a 2-bit saturating direction counter. A fetch address that matches no stored branch simply falls through to the next word. Ordinary instructions are never written into the table, so they can never cause a spurious redirect.

The execute stage reports each resolved control instruction on the resolve side. It gives the instruction address, whether it was taken, its real destination and the next PC that fetch actually used after it. The block compares the used next PC with the correct one in the same cycle. On a mismatch it raises a kill request and returns the correct restart address. On the following clock edge it trains the matching slot, or it claims a slot for a taken branch that missed.

Top module: `fetch_target_buffer`

## Requirements
- R1: Reset clears every valid flag. Until something is allocated, every fetch address gives `fetchHit` = 0 and `nextPc` = `fetchPc` + 4, and this also holds while reset is asserted.
- R2: The slot index is `fetchPc[IDX_W+1:2]` (16 slots by default). A hit needs a valid slot whose stored tag equals the whole fetch address. Another address with the same index does not hit.
- R3: In the same cycle as `fetchPc`, `nextPc` is the stored destination when the slot hits and the counter's upper bit is 1. In every other case it is `fetchPc` + 4.
- R4: A taken resolve that misses claims its slot and replaces any previous occupant. The slot gets tag = `resPc`, destination = `resTarget` and counter 2 (weakly taken).
- R5: A not-taken resolve that misses writes nothing. That address keeps missing afterwards.
- R6: A resolve that hits moves the counter up by one when taken and down by one when not taken. The counter saturates at 0 and at 3, and values 2 and 3 predict taken.
- R7: A taken resolve that hits replaces the stored destination with `resTarget`.
- R8: While `resValid` is 1, `kill` is 1 in the same cycle exactly when `resPredPc` differs from the correct next PC. The correct next PC is `resTarget` if taken, otherwise `resPc` + 4, and it appears on `redirectPc`. `kill` is 0 whenever `resValid` is 0.
- R9: Table writes take effect at the clock edge. A fetch lookup on the slot being written in that same cycle sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fetchPc | input | PC_W | Current fetch address |
| nextPc | output | PC_W | Predicted next fetch address |
| fetchHit | output | 1 | Fetch address matched a valid slot |
| resValid | input | 1 | A resolved control instruction is presented |
| resPc | input | PC_W | Address of the resolved instruction |
| resTaken | input | 1 | Resolved direction |
| resTarget | input | PC_W | Resolved destination |
| resPredPc | input | PC_W | Next PC that fetch used after this instruction |
| kill | output | 1 | Wrong-path instructions must be discarded |
| redirectPc | output | PC_W | Correct restart address |

## Verification
The fetch lookup and the resolve-side write can fall on the same slot in one cycle. This is provoked by presenting the resolved address on `fetchPc` in the very cycle its allocation or counter update is issued. The bench judges the result by requiring the previous prediction in that cycle and the new one in the next. The same pairing is used across counter transitions, so a lookup that saw the write early would show up as a wrong `nextPc`.

// File: rtl/btb_pkg.sv
package btb_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_MIN        = 2'b00;
  localparam ctr_t CTR_MAX        = 2'b11;
  localparam ctr_t CTR_WEAK_TAKEN = 2'b10;

  // Write strobes from the control to the storage datapath
  typedef struct packed {
    logic wrEn;      // write counter of the resolve slot
    logic alloc;     // (re)claim slot: set valid and tag
    logic wrTarget;  // overwrite stored destination
    ctr_t newCtr;    // counter value to store
  } btbStrobe_t;

endpackage

// File: rtl/btb_datapath.sv
module btb_datapath
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PC_W-1:0]  fetchPc,
  output logic [PC_W-1:0]  nextPc,
  output logic             fetchHit,
  input  logic [PC_W-1:0]  resPc,
  input  logic [PC_W-1:0]  resTarget,
  input  btbStrobe_t       strb,
  output logic             resHit,
  output ctr_t             resCtr
);

  localparam int ENTRIES = 1 << IDX_W;
  localparam int IDX_LO  = 2;
  localparam int IDX_HI  = IDX_LO + IDX_W - 1;
  localparam logic [PC_W-1:0] STEP = PC_W'(4);

  logic [ENTRIES-1:0] validQ;
  logic [PC_W-1:0]    tagQ [ENTRIES];
  logic [PC_W-1:0]    tgtQ [ENTRIES];
  ctr_t               ctrQ [ENTRIES];

  logic [IDX_W-1:0] fIdx;
  logic [IDX_W-1:0] rIdx;

  assign fIdx = fetchPc[IDX_HI:IDX_LO];
  assign rIdx = resPc[IDX_HI:IDX_LO];

  // Fetch-side lookup, combinational in the fetch cycle
  always_comb begin
    fetchHit = validQ[fIdx] && (tagQ[fIdx] == fetchPc);
    if (fetchHit && ctrQ[fIdx][1]) nextPc = tgtQ[fIdx];
    else                           nextPc = fetchPc + STEP;
  end

  // Resolve-side read port for training
  always_comb begin
    resHit = validQ[rIdx] && (tagQ[rIdx] == resPc);
    resCtr = ctrQ[rIdx];
  end

  // One storage slot per entry
  for (genvar g = 0; g < ENTRIES; g++) begin : gSlot
    logic selW;
    assign selW = strb.wrEn && (rIdx == IDX_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validQ[g] <= 1'b0;
        tagQ[g]   <= '0;
        tgtQ[g]   <= '0;
        ctrQ[g]   <= CTR_MIN;
      end else if (selW) begin
        ctrQ[g] <= strb.newCtr;
        if (strb.alloc) begin
          validQ[g] <= 1'b1;
          tagQ[g]   <= resPc;
        end
        if (strb.wrTarget) tgtQ[g] <= resTarget;
      end
    end
  end

  // R4: an allocated slot is valid and tagged with the resolved address one edge later
  p_alloc_visible_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.alloc |=> (validQ[$past(rIdx)] && tagQ[$past(rIdx)] == $past(resPc)));

  // R5: without a write strobe no valid flag changes
  p_quiet_keeps_valid_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrEn |=> $stable(validQ));

  // R7: a target write is visible on the following edge
  p_target_written_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && strb.wrTarget) |=> (tgtQ[$past(rIdx)] == $past(resTarget)));

endmodule

// File: rtl/btb_control.sv
module btb_control
  import btb_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             resValid,
  input  logic [PC_W-1:0]  resPc,
  input  logic             resTaken,
  input  logic [PC_W-1:0]  resTarget,
  input  logic [PC_W-1:0]  resPredPc,
  input  logic             resHit,
  input  ctr_t             resCtr,
  output btbStrobe_t       strb,
  output logic             kill,
  output logic [PC_W-1:0]  redirectPc
);

  localparam logic [PC_W-1:0] STEP = PC_W'(4);

  ctr_t trained;

  // Saturating counter step
  always_comb begin
    trained = resCtr;
    if (resTaken) begin
      if (resCtr != CTR_MAX) trained = resCtr + 2'd1;
    end else begin
      if (resCtr != CTR_MIN) trained = resCtr - 2'd1;
    end
  end

  always_comb begin
    strb.alloc    = resValid && resTaken && !resHit;
    strb.wrEn     = resValid && (resHit || resTaken);
    strb.wrTarget = resValid && resTaken;
    strb.newCtr   = strb.alloc ? CTR_WEAK_TAKEN : trained;
  end

  // Misprediction detection against the address fetch really used
  always_comb begin
    redirectPc = resTaken ? resTarget : (resPc + STEP);
    kill       = resValid && (resPredPc != redirectPc);
  end

  // R6: counter never wraps past the top
  p_ctr_sat_hi_r6: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resHit && resTaken && resCtr == CTR_MAX) |-> (strb.newCtr == CTR_MAX));

  // R6: counter never wraps past the bottom
  p_ctr_sat_lo_r6: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resHit && !resTaken && resCtr == CTR_MIN) |-> (strb.newCtr == CTR_MIN));

  // R5: a not-taken miss issues no write
  p_nt_miss_silent_r5: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resTaken && !resHit) |-> !strb.wrEn);

endmodule

// File: rtl/fetch_target_buffer.sv
module fetch_target_buffer
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PC_W-1:0]  fetchPc,
  output logic [PC_W-1:0]  nextPc,
  output logic             fetchHit,
  input  logic             resValid,
  input  logic [PC_W-1:0]  resPc,
  input  logic             resTaken,
  input  logic [PC_W-1:0]  resTarget,
  input  logic [PC_W-1:0]  resPredPc,
  output logic             kill,
  output logic [PC_W-1:0]  redirectPc
);

  btbStrobe_t strb;
  logic       resHit;
  ctr_t       resCtr;

  btb_datapath #(.PC_W(PC_W), .IDX_W(IDX_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .fetchPc   (fetchPc),
    .nextPc    (nextPc),
    .fetchHit  (fetchHit),
    .resPc     (resPc),
    .resTarget (resTarget),
    .strb      (strb),
    .resHit    (resHit),
    .resCtr    (resCtr)
  );

  btb_control #(.PC_W(PC_W)) ctl_i (
    .clk        (clk),
    .rstN       (rstN),
    .resValid   (resValid),
    .resPc      (resPc),
    .resTaken   (resTaken),
    .resTarget  (resTarget),
    .resPredPc  (resPredPc),
    .resHit     (resHit),
    .resCtr     (resCtr),
    .strb       (strb),
    .kill       (kill),
    .redirectPc (redirectPc)
  );

  // R3: a fetch that misses always falls through to the next word
  p_miss_falls_through_r3: assert property (@(posedge clk) disable iff (!rstN)
    !fetchHit |-> (nextPc == fetchPc + PC_W'(4)));

  // R8: no kill without a resolve
  p_no_kill_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> !kill);

endmodule

// File: tb/fetch_target_buffer_tb_top.sv
module fetch_target_buffer_tb_top;

  localparam int PC_W = 32;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [PC_W-1:0] fetchPc = '0;
  logic [PC_W-1:0] nextPc;
  logic            fetchHit;
  logic            resValid = 1'b0;
  logic [PC_W-1:0] resPc = '0;
  logic            resTaken = 1'b0;
  logic [PC_W-1:0] resTarget = '0;
  logic [PC_W-1:0] resPredPc = '0;
  logic            kill;
  logic [PC_W-1:0] redirectPc;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  fetch_target_buffer #(.PC_W(PC_W), .IDX_W(4)) dut_i (
    .clk(clk), .rstN(rstN), .fetchPc(fetchPc), .nextPc(nextPc), .fetchHit(fetchHit),
    .resValid(resValid), .resPc(resPc), .resTaken(resTaken), .resTarget(resTarget),
    .resPredPc(resPredPc), .kill(kill), .redirectPc(redirectPc)
  );

  typedef struct packed {
    logic        rv;
    logic [31:0] rpc;
    logic        rt;
    logic [31:0] rtgt;
    logic [31:0] rpred;
    logic [31:0] fpc;
    logic [31:0] eNext;
    logic        eHit;
    logic        eKill;
    logic [31:0] eRedir;
    logic [7:0]  req;
  } vec_t;

  function automatic vec_t mk(logic rv, logic [31:0] rpc, logic rt, logic [31:0] rtgt,
                              logic [31:0] rpred, logic [31:0] fpc, logic [31:0] eNext,
                              logic eHit, logic eKill, logic [31:0] eRedir, logic [7:0] req);
    mk = '{rv, rpc, rt, rtgt, rpred, fpc, eNext, eHit, eKill, eRedir, req};
  endfunction

  // A=0x100 idx0, alias C=0x140 idx0, B=0x208 idx2, D=0x3FC idx15
  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    mk(0, 32'h0,   0, 32'h0,   32'h0,   32'h100, 32'h104, 0, 0, 32'h0,   1), // R1 empty
    mk(1, 32'h100, 1, 32'h200, 32'h104, 32'h100, 32'h104, 0, 1, 32'h200, 9), // R9 old contents, R8 kill
    mk(0, 32'h0,   0, 32'h0,   32'h0,   32'h100, 32'h200, 1, 0, 32'h0,   4), // R4 allocated weakly taken
    mk(0, 32'h0,   0, 32'h0,   32'h0,   32'h140, 32'h144, 0, 0, 32'h0,   2), // R2 alias misses
    mk(1, 32'h100, 0, 32'h0,   32'h200, 32'h140, 32'h144, 0, 1, 32'h104, 8), // R8 nt redirect
    mk(0, 32'h0,   0, 32'h0,   32'h0,   32'h100, 32'h104, 1, 0, 32'h0,   6), // R6 ctr 1
    mk(1, 32'h100, 0, 32'h0,   32'h104, 32'h100, 32'h104, 1, 0, 32'h0,   8), // R8 correct, ctr->0
    mk(1, 32'h100, 0, 32'h0,   32'h104, 32'h100, 32'h104, 1, 0, 32'h0,   6), // R6 sat at 0
    mk(1, 32'h100, 1, 32'h200, 32'h104, 32'h100, 32'h104, 1, 1, 32'h200, 6), // R6 no wrap to 3
    mk(0, 32'h0,   0, 32'h0,   32'h0,   32'h100, 32'h104, 1, 0, 32'h0,   6), // R6 ctr 1
    mk(1, 32'h100, 1, 32'h300, 32'h104, 32'h300, 32'h304, 0, 1, 32'h300, 7), // R7 new target
    mk(0, 32'h0,   0, 32'h0,   32'h0,   32'h100, 32'h300, 1, 0, 32'h0,   7), // R7 target visible
    mk(1, 32'h100, 1, 32'h300, 32'h300, 32'h100, 32'h300, 1, 0, 32'h0,   6), // R6 ctr->3
    mk(1, 32'h100, 1, 32'h300, 32'h300, 32'h100, 32'h300, 1, 0, 32'h0,   6), // R6 sat at 3
    mk(1, 32'h100, 0, 32'h0,   32'h300, 32'h100, 32'h300, 1, 1, 32'h104, 8), // R8 ctr->2
    mk(1, 32'h100, 0, 32'h0,   32'h104, 32'h100, 32'h300, 1, 0, 32'h0,   6), // R6 ctr 2 -> 1
    mk(0, 32'h0,   0, 32'h0,   32'h0,   32'h100, 32'h104, 1, 0, 32'h0,   6), // R6 no wrap from 3
    mk(1, 32'h208, 0, 32'h0,   32'h20C, 32'h208, 32'h20C, 0, 0, 32'h0,   5), // R5 nt miss
    mk(0, 32'h0,   0, 32'h0,   32'h0,   32'h208, 32'h20C, 0, 0, 32'h0,   5), // R5 still miss
    mk(1, 32'h140, 1, 32'h500, 32'h144, 32'h100, 32'h104, 1, 1, 32'h500, 4), // R4 evict A
    mk(0, 32'h0,   0, 32'h0,   32'h0,   32'h100, 32'h104, 0, 0, 32'h0,   4), // R4 A gone
    mk(0, 32'h0,   0, 32'h0,   32'h0,   32'h140, 32'h500, 1, 0, 32'h0,   4), // R4 C present
    mk(1, 32'h3FC, 1, 32'h10,  32'h10,  32'h3FC, 32'h400, 0, 0, 32'h0,   9), // R9 old, R8 no kill on miss
    mk(0, 32'h0,   0, 32'h0,   32'h0,   32'h3FC, 32'h10,  1, 0, 32'h0,   2), // R2 top index
    mk(0, 32'h100, 1, 32'h0,   32'hDEAD,32'h3FC, 32'h10,  1, 0, 32'h0,   8)  // R8 idle no kill
  };

  task automatic chk(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    resValid  = v.rv;
    resPc     = v.rpc;
    resTaken  = v.rt;
    resTarget = v.rtgt;
    resPredPc = v.rpred;
    fetchPc   = v.fpc;
  endtask

  task automatic report();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    // R1: outputs during reset
    fetchPc = 32'h100;
    #2;
    chk(1, "hit in reset", {31'b0, fetchHit}, 32'h0);
    chk(1, "next in reset", nextPc, 32'h104);
    chk(8, "kill in reset idle", {31'b0, kill}, 32'h0);
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      #2;
      chk(int'(VEC[i].req), $sformatf("vec%0d nextPc", i), nextPc, VEC[i].eNext);
      chk(int'(VEC[i].req), $sformatf("vec%0d fetchHit", i), {31'b0, fetchHit}, {31'b0, VEC[i].eHit});
      chk(int'(VEC[i].req), $sformatf("vec%0d kill", i), {31'b0, kill}, {31'b0, VEC[i].eKill});
      if (VEC[i].eKill)
        chk(int'(VEC[i].req), $sformatf("vec%0d redirectPc", i), redirectPc, VEC[i].eRedir);
    end

    // R1: reset in mid-run clears slots
    @(negedge clk);
    resValid = 1'b0;
    rstN = 1'b0;
    fetchPc = 32'h3FC;
    #2;
    chk(1, "D after reset", nextPc, 32'h400);
    @(negedge clk);
    rstN = 1'b1;
    fetchPc = 32'h140;
    #2;
    chk(1, "C hit after reset", {31'b0, fetchHit}, 32'h0);
    chk(1, "C next after reset", nextPc, 32'h144);

    // R4: fresh allocation predicts taken immediately after edge (weakly taken)
    resValid = 1'b1; resPc = 32'h208; resTaken = 1'b1; resTarget = 32'h800; resPredPc = 32'h20C;
    fetchPc = 32'h208;
    #1;
    chk(8, "alloc kill", {31'b0, kill}, 32'h1);
    @(negedge clk);
    resValid = 1'b0;
    #2;
    chk(4, "B allocated", nextPc, 32'h800);
    // R6: one not-taken from weakly taken drops to not taken
    resValid = 1'b1; resTaken = 1'b0; resPredPc = 32'h800;
    @(negedge clk);
    resValid = 1'b0;
    #2;
    chk(6, "B weakly not taken", nextPc, 32'h20C);
    chk(6, "B still hits", {31'b0, fetchHit}, 32'h1);

    finished = 1;
    report();
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL R0 watchdog actual=%h expected=%h", 32'h0, 32'h1);
      report();
    end
  end

endmodule